// File: doc/BRIEF.md
# Processor Status and Width-Mode Controller

This block keeps the eight condition and control flags of a processor core whose accumulator and index registers can each be 8 or 16 bits wide. It also keeps a separate compatibility bit that selects a narrow, legacy-style operating mode. The core's decoder sends it one request per cycle, qualified by a strobe. A request can clear flags under a mask, set flags under a mask, swap the carry flag with the compatibility bit, or load the sign and zero flags from a result that is 8 or 16 bits wide.

From the stored state the block drives three width selects, for the accumulator, the index registers and the stack pointer. While the compatibility bit is 1, all three are narrow. In that mode the two width-control flags are held at 1, so a masked clear cannot widen a register. Every output is registered. A request presented in one cycle shows at the outputs after the next rising clock edge.

Top module: `pstat_width_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flags` is 8'h34 and `emu` is 1, so the accumulator, index and stack width selects are all 0. This means bits 5, 4 and 2 are set and every other flag is 0.
- R2: Op code 2'b00 with `op_valid` high replaces the flags with `flags & ~op_mask`, except for the bits that R5 holds.
- R3: Op code 2'b01 with `op_valid` high replaces the flags with `flags | op_mask`.
- R4: Op code 2'b10 with `op_valid` high swaps carry (bit 0) with `emu`. The other flags are unchanged, apart from the forcing in R5.
- R5: Whenever `emu` is 1, bit 5 (accumulator width) and bit 4 (index width, which serves as the break indicator in this mode) read as 1. A clear that targets them has no effect. Entering the compatibility mode sets both bits.
- R6: `acc_wide` is 1 only when `emu` is 0 and bit 5 is 0. `idx_wide` is 1 only when `emu` is 0 and bit 4 is 0. `stk_wide` equals the inverse of `emu`.
- R7: Op code 2'b11 with `op_valid` high sets bit 7 from bit 15 of `res_value` when `res_wide` is 1, or from bit 7 when it is 0. It sets bit 1 when the result is zero at that width. All other bits are unchanged.
- R8: When `op_valid` is low, `flags` and `emu` hold their values whatever `op_code`, `op_mask` and `res_value` carry. An accepted request appears at the outputs one clock edge after it is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies the request for this cycle |
| op_code | input | 2 | 00 clear under mask, 01 set under mask, 10 carry/mode swap, 11 sign/zero update |
| op_mask | input | 8 | Flag mask for clear and set |
| res_value | input | RES_W (16) | Result for the sign/zero update |
| res_wide | input | 1 | 1 = judge result at full width, 0 = low LO_W bits |
| flags | output | 8 | Flag vector, bit 7 sign down to bit 0 carry |
| emu | output | 1 | Compatibility (narrow) mode bit |
| acc_wide | output | 1 | Accumulator is 16 bits wide |
| idx_wide | output | 1 | Index registers are 16 bits wide |
| stk_wide | output | 1 | Stack pointer is 16 bits wide |

## Verification
The bench builds the block with its default parameters: RES_W of 16, LO_W of 8, and mode locking enabled. With these values a single result can be judged at both widths. The run checks that the sign bit moves between bit 7 and bit 15 as the width changes, and that zero detection looks only at the low byte in narrow mode. Enabling the lock variant lets the run show that a masked clear of the width flags is ignored in compatibility mode but takes effect in native mode. It also shows the full sequence of entering and leaving that mode through the carry swap.

// File: rtl/ps_pkg.sv
package ps_pkg;

   typedef enum logic [1:0] {
      PS_OP_CLR  = 2'b00,
      PS_OP_SET  = 2'b01,
      PS_OP_SWAP = 2'b10,
      PS_OP_NZ   = 2'b11
   } ps_op_e;

   localparam int FLAG_W = 8;
   localparam int BIT_N  = 7;
   localparam int BIT_M  = 5;
   localparam int BIT_X  = 4;
   localparam int BIT_I  = 2;
   localparam int BIT_Z  = 1;
   localparam int BIT_C  = 0;

   // narrow widths, interrupts masked, decimal clear, remaining flags zero
   localparam logic [FLAG_W-1:0] FLAGS_RST = 8'h34;

endpackage

// File: rtl/ps_nz_eval.sv
module ps_nz_eval #(
   parameter int RES_W = 16,
   parameter int LO_W  = 8
) (
   input  logic [RES_W-1:0] res,
   input  logic             wide,
   output logic             neg,
   output logic             zero
);
   logic lo_zero;
   logic hi_zero;

   assign lo_zero = ~|res[LO_W-1:0];

   generate
      if (RES_W > LO_W) begin : g_hi
         assign hi_zero = ~|res[RES_W-1:LO_W];
      end else begin : g_no_hi
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      if (wide) begin
         neg  = res[RES_W-1];
         zero = lo_zero & hi_zero;
      end else begin
         neg  = res[LO_W-1];
         zero = lo_zero;
      end
   end
endmodule

// File: rtl/ps_width_decode.sv
module ps_width_decode (
   input  logic emu,
   input  logic m_flag,
   input  logic x_flag,
   output logic acc_wide,
   output logic idx_wide,
   output logic stk_wide
);
   always_comb begin
      stk_wide = ~emu;
      acc_wide = ~emu & ~m_flag;
      idx_wide = ~emu & ~x_flag;
   end
endmodule

// File: rtl/ps_flag_reg.sv
module ps_flag_reg
   import ps_pkg::*;
#(
   parameter bit LOCK_IN_EMU = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  ps_op_e            op,
   input  logic [FLAG_W-1:0] mask,
   input  logic              nz_neg,
   input  logic              nz_zero,
   output logic [FLAG_W-1:0] p_q,
   output logic              emu_q
);
   logic [FLAG_W-1:0] p_op;
   logic [FLAG_W-1:0] p_nxt;
   logic              emu_nxt;

   always_comb begin
      p_op    = p_q;
      emu_nxt = emu_q;
      if (valid) begin
         unique case (op)
            PS_OP_CLR:  p_op = p_q & ~mask;
            PS_OP_SET:  p_op = p_q | mask;
            PS_OP_SWAP: begin
               p_op[BIT_C] = emu_q;
               emu_nxt     = p_q[BIT_C];
            end
            PS_OP_NZ: begin
               p_op[BIT_N] = nz_neg;
               p_op[BIT_Z] = nz_zero;
            end
            default: p_op = p_q;
         endcase
      end
   end

   generate
      if (LOCK_IN_EMU) begin : g_lock
         always_comb begin
            p_nxt = p_op;
            if (emu_nxt) begin
               p_nxt[BIT_M] = 1'b1;
               p_nxt[BIT_X] = 1'b1;
            end
         end
         AST_EMU_WIDTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            emu_q |-> (p_q[BIT_M] && p_q[BIT_X])); // R5
      end else begin : g_free
         assign p_nxt = p_op;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_q   <= FLAGS_RST;
         emu_q <= 1'b1;
      end else begin
         p_q   <= p_nxt;
         emu_q <= emu_nxt;
      end
   end

   AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == PS_OP_SET) |=> ((p_q & $past(mask)) == $past(mask))); // R3

   AST_SWAP_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == PS_OP_SWAP) |=> (emu_q == $past(p_q[BIT_C]) && p_q[BIT_C] == $past(emu_q))); // R4
endmodule

// File: rtl/pstat_width_ctrl.sv
module pstat_width_ctrl
   import ps_pkg::*;
#(
   parameter int RES_W       = 16,
   parameter int LO_W        = 8,
   parameter bit LOCK_IN_EMU = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       op_code,
   input  logic [7:0]       op_mask,
   input  logic [RES_W-1:0] res_value,
   input  logic             res_wide,
   output logic [7:0]       flags,
   output logic             emu,
   output logic             acc_wide,
   output logic             idx_wide,
   output logic             stk_wide
);
   localparam int HI_W = RES_W - LO_W;

   generate
      if (LO_W < 1 || HI_W < 1) begin : g_bad_width
         $error("pstat_width_ctrl: need 1 <= LO_W < RES_W");
      end
   endgenerate

   ps_op_e op_e;
   logic   nz_neg;
   logic   nz_zero;

   assign op_e = ps_op_e'(op_code);

   ps_nz_eval #(.RES_W(RES_W), .LO_W(LO_W)) u_nz (
      .res  (res_value),
      .wide (res_wide),
      .neg  (nz_neg),
      .zero (nz_zero)
   );

   ps_flag_reg #(.LOCK_IN_EMU(LOCK_IN_EMU)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (op_valid),
      .op      (op_e),
      .mask    (op_mask),
      .nz_neg  (nz_neg),
      .nz_zero (nz_zero),
      .p_q     (flags),
      .emu_q   (emu)
   );

   ps_width_decode u_wid (
      .emu      (emu),
      .m_flag   (flags[BIT_M]),
      .x_flag   (flags[BIT_X]),
      .acc_wide (acc_wide),
      .idx_wide (idx_wide),
      .stk_wide (stk_wide)
   );

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(flags) && $stable(emu))); // R8

   AST_CLR_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'b00 && !emu) |=> ((flags & $past(op_mask)) == 8'h00)); // R2

   AST_EMU_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      emu |-> (!acc_wide && !idx_wide && !stk_wide)); // R6

   AST_NZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'b11) |=> !(flags[BIT_N] && flags[BIT_Z])); // R7

   AST_NZ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'b11) |=> ((flags & 8'h7D) == ($past(flags) & 8'h7D))); // R7

   AST_RST_STATE: assert property (@(posedge clk)
      !rst_n |=> (emu && flags == FLAGS_RST)); // R1
endmodule

// File: tb/pstat_width_ctrl_test.sv
module pstat_width_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = 2'b00;
   logic [7:0]  op_mask = 8'h00;
   logic [15:0] res_value = 16'h0000;
   logic        res_wide = 1'b0;
   logic [7:0]  flags;
   logic        emu;
   logic        acc_wide;
   logic        idx_wide;
   logic        stk_wide;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pstat_width_ctrl uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_mask(op_mask), .res_value(res_value), .res_wide(res_wide),
      .flags(flags), .emu(emu), .acc_wide(acc_wide), .idx_wide(idx_wide),
      .stk_wide(stk_wide)
   );

   // fields: op[38:37] mask[36:29] val[28:13] wide[12] flags[11:4] emu[3] {acc,idx,stk}[2:0]
   localparam int NV = 16;
   localparam logic [38:0] VEC [NV] = '{
      {2'd0, 8'h30, 16'h0000, 1'b0, 8'h34, 1'b1, 3'b000}, // R5 clear ignored in emu
      {2'd1, 8'h01, 16'h0000, 1'b0, 8'h35, 1'b1, 3'b000}, // R3
      {2'd0, 8'h01, 16'h0000, 1'b0, 8'h34, 1'b1, 3'b000}, // R2
      {2'd2, 8'h00, 16'h0000, 1'b0, 8'h35, 1'b0, 3'b001}, // R4 enter native
      {2'd0, 8'h30, 16'h0000, 1'b0, 8'h05, 1'b0, 3'b111}, // R2 R6
      {2'd3, 8'h00, 16'h8000, 1'b1, 8'h85, 1'b0, 3'b111}, // R7 wide sign
      {2'd3, 8'h00, 16'h0080, 1'b0, 8'h85, 1'b0, 3'b111}, // R7 narrow sign
      {2'd3, 8'h00, 16'h1200, 1'b0, 8'h07, 1'b0, 3'b111}, // R7 narrow zero
      {2'd3, 8'h00, 16'h1200, 1'b1, 8'h05, 1'b0, 3'b111}, // R7 wide nonzero
      {2'd1, 8'hC8, 16'h0000, 1'b0, 8'hCD, 1'b0, 3'b111}, // R3
      {2'd0, 8'hFF, 16'h0000, 1'b0, 8'h00, 1'b0, 3'b111}, // R2 all
      {2'd1, 8'h20, 16'h0000, 1'b0, 8'h20, 1'b0, 3'b011}, // R6 narrow acc
      {2'd2, 8'h00, 16'h0000, 1'b0, 8'h20, 1'b0, 3'b011}, // R4 both zero
      {2'd1, 8'h01, 16'h0000, 1'b0, 8'h21, 1'b0, 3'b011}, // R3
      {2'd2, 8'h00, 16'h0000, 1'b0, 8'h30, 1'b1, 3'b000}, // R4 R5 enter emu
      {2'd3, 8'h00, 16'h0000, 1'b1, 8'h32, 1'b1, 3'b000}  // R7 in emu
   };

   function automatic string row_tag(int i);
      case (i)
         0: return "R5";
         1, 9, 13: return "R3";
         2, 10: return "R2";
         3, 12: return "R4";
         4, 11: return "R6";
         14: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(logic [1:0] op, logic [7:0] m, logic [15:0] v, logic w, logic vld);
      @(negedge clk);
      op_code = op; op_mask = m; res_value = v; res_wide = w; op_valid = vld;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during and after reset
      chk("R1 flags in reset", {8'h00, flags}, 16'h0034);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags", {8'h00, flags}, 16'h0034);
      chk("R1 emu", {15'h0, emu}, 16'h0001);
      chk("R1 widths", {13'h0, acc_wide, idx_wide, stk_wide}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         put(VEC[i][38:37], VEC[i][36:29], VEC[i][28:13], VEC[i][12], 1'b1);
         chk($sformatf("%s row %0d flags", row_tag(i), i), {8'h00, flags}, {8'h00, VEC[i][11:4]});
         chk($sformatf("%s row %0d emu", row_tag(i), i), {15'h0, emu}, {15'h0, VEC[i][3]});
         chk($sformatf("R6 row %0d widths", i), {13'h0, acc_wide, idx_wide, stk_wide},
             {13'h0, VEC[i][2:0]});
      end

      // R8: requests without strobe change nothing
      put(2'd1, 8'hFF, 16'h0000, 1'b0, 1'b0);
      chk("R8 idle set", {7'h0, emu, flags}, {7'h0, 1'b1, 8'h32});
      put(2'd2, 8'h00, 16'h0000, 1'b0, 1'b0);
      chk("R8 idle swap", {7'h0, emu, flags}, {7'h0, 1'b1, 8'h32});

      // R8 latency: output unchanged before the edge that takes the request
      @(negedge clk);
      op_code = 2'd1; op_mask = 8'h01; op_valid = 1'b1;
      #1;
      chk("R8 before edge", {8'h00, flags}, 16'h0032);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R8 after edge", {8'h00, flags}, 16'h0033);

      // native: widen index only, then narrow again (R2 R6)
      put(2'd0, 8'h01, 16'h0000, 1'b0, 1'b1); // C=0 -> 0x32
      put(2'd2, 8'h00, 16'h0000, 1'b0, 1'b1); // native, C=1 -> 0x33
      put(2'd0, 8'h10, 16'h0000, 1'b0, 1'b1); // X=0 -> 0x23
      chk("R2 clear X native", {8'h00, flags}, 16'h0023);
      chk("R6 index wide only", {13'h0, acc_wide, idx_wide, stk_wide}, 16'h0003);

      // mid-run reset (R1)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 re-reset", {7'h0, emu, flags}, {7'h0, 1'b1, 8'h34});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule